// File: doc/BRIEF.md
# Bus Parity Error Reporter

This block watches a 32-bit multiplexed address/data bus of the PCI kind. It checks the parity of every address phase and every completed data phase, and raises the two error pins with the bus's own timing. Data parity errors that the agent itself received go out on the parity-error pin. Address parity errors, and data parity errors in broadcast Special Cycles, go out on the system-error pin. Each pin has its own output-enable signal, which stands in for the tri-state pad.

The block runs on the bus clock. It needs to know whether the agent is currently the bus master and whether it has claimed the current access as a target. The parity computed for a phase is held for one clock and then compared with the PAR value that arrives on the next clock. A mismatch fires the selected pin on the following edge, so the pin is sampled active two rising edges after the faulty phase.

Two enable inputs gate the pins. Two sticky flags record what happened, and each flag is cleared by writing a one to its bit of the clear input.

Top module: `bus_parity_monitor`

## Requirements
- R1: The expected PAR is the even parity over `ad` and `cbe_n`: the XOR of all 36 bits. The `par` input sampled on the clock after a checked phase is compared with it, and a difference is an error.
- R2: A data phase is checked only on a clock where `irdy_n` and `trdy_n` are both low. Wait clocks are ignored, even when their parity is wrong.
- R3: For a faulty data phase that is reported, `perr_n` is low for exactly the clock after the PAR sample. It is therefore sampled low on the second rising edge after the data phase. Back-to-back faulty phases keep it low for one clock per phase.
- R4: `perr_n` reports only data that the agent received. As master (`is_master`=1) this means read commands (`cbe_n[0]`=0 in the address phase). As target it means write commands (`cbe_n[0]`=1), and only when `devsel_n` is low in that data phase.
- R5: A data parity error during a Special Cycle (address-phase command `cbe_n`=4'b0001), seen while the agent is not master, is reported as a one-clock pulse on `serr_n` and never on `perr_n`.
- R6: An address parity error seen while the agent is not master is reported as a one-clock pulse on `serr_n`, with the same delay as R3. The master never reports address parity.
- R7: When `perr_en`=0 the `perr_n` pin stays released (high, `perr_oe`=0). When `serr_en`=0 the same holds for `serr_n` and `serr_oe`.
- R8: Each output enable is high while its pin is low and for exactly one clock after, with the pin driven high in that clock. At all other times the enable is low and the pin is high.
- R9: `err_seen` is set by any error that R4, R5 or R6 makes this agent responsible for, whatever the enables. `serr_sent` is set whenever `serr_n` fires. `flag_clr[0]` clears `err_seen` and `flag_clr[1]` clears `serr_sent`. A set in the same clock as a clear wins.
- R10: In reset both pins are high, both enables are low and both flags are 0.
- R11: An address phase is recognized only on a clock where `frame_n` is low and the previous clock was idle (`frame_n` and `irdy_n` both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command / byte enables, active low |
| par | input | 1 | Parity of the previous clock's phase |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Agent has claimed the access as target, active low |
| is_master | input | 1 | Agent is master of the current transaction |
| perr_en | input | 1 | Allows the parity-error pin to be driven |
| serr_en | input | 1 | Allows the system-error pin to be driven |
| flag_clr | input | 2 | Write-one-to-clear for the sticky flags |
| perr_n | output | 1 | Data parity error pin value, active low |
| perr_oe | output | 1 | Output enable for perr_n |
| serr_n | output | 1 | System error pin value, active low |
| serr_oe | output | 1 | Output enable for serr_n |
| err_seen | output | 1 | Sticky: parity error detected |
| serr_sent | output | 1 | Sticky: system error signalled |

## Verification
The bench runs reads as master and writes as target with single faulty phases, with two adjacent faulty phases and with wait clocks of bad parity. These patterns separate a correct two-clock delay and per-phase pulse from an off-by-one, from merged pulses and from checking wait clocks. It also sends faulty data in the wrong direction, without a claim and in Special Cycles, and sends faulty address phases both as master and after a clock that was not idle. These cases separate the routing between the two pins from over-eager reporting. Runs with the enables off, and a clear that lands on the same edge as a new error, separate the sticky flags from the pin gating.

// File: rtl/bpm_pkg.sv
// Shared types for the bus parity error reporter.
// Assumes a 4-bit command field in cbe_n[3:0] during address phases.
package bpm_pkg;
    localparam logic [3:0] CMD_SPECIAL = 4'b0001;

    // What kind of check the held phase needs on the following clock
    typedef enum logic [1:0] {
        CHK_NONE,
        CHK_ADDR,
        CHK_PDATA,
        CHK_SDATA
    } chk_kind_e;

    // Output pin driver states
    typedef enum logic [1:0] {
        PIN_IDLE,
        PIN_ACTIVE,
        PIN_PARK
    } pin_state_e;
endpackage

// File: rtl/bpm_phase_track.sv
// Phase tracker: finds address phases and completed data phases. It decides
// which check (if any) the agent owns for the phase and registers the
// expected parity together with that check kind.
// Assumes all bus inputs are synchronous to clk and already inverted-logic (active low).
module bpm_phase_track
    import bpm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CBE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [CBE_W-1:0]  cbe_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              devsel_n,
    input  logic              is_master,
    output chk_kind_e         kind_q,
    output logic              exp_par_q
);
    logic       frame_q;
    logic       irdy_q;
    logic       in_xfer;
    logic [3:0] cmd_q;
    logic       addr_ph;
    logic       data_ph;
    logic       receiver;
    chk_kind_e  kind_d;

    assign addr_ph  = !frame_n && frame_q && irdy_q;
    assign data_ph  = in_xfer && !addr_ph && !irdy_n && !trdy_n;
    assign receiver = is_master ? !cmd_q[0] : (cmd_q[0] && !devsel_n);

    // Select the check kind for the current clock
    always_comb begin
        kind_d = CHK_NONE;
        if (addr_ph) begin
            if (!is_master) kind_d = CHK_ADDR;
        end else if (data_ph) begin
            if (cmd_q == CMD_SPECIAL) begin
                if (!is_master) kind_d = CHK_SDATA;
            end else if (receiver) begin
                kind_d = CHK_PDATA;
            end
        end
    end

    // Remember the previous bus state for idle detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b1;
            irdy_q  <= 1'b1;
        end else begin
            frame_q <= frame_n;
            irdy_q  <= irdy_n;
        end
    end

    // Track transaction span and latch the command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_xfer <= 1'b0;
            cmd_q   <= '1;
        end else if (addr_ph) begin
            in_xfer <= 1'b1;
            cmd_q   <= cbe_n[3:0];
        end else if (data_ph && frame_n) begin
            in_xfer <= 1'b0;
        end
    end

    // Hold the expected parity and check kind for the next clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= CHK_NONE;
            exp_par_q <= 1'b0;
        end else begin
            kind_q    <= kind_d;
            exp_par_q <= ^{ad, cbe_n};
        end
    end
endmodule

// File: rtl/bpm_pin_drv.sv
// Error pin driver: one clock active low per fire, then one clock driven
// high, then the output enable is released. A new fire restarts the pulse.
// Assumes fire is a registered-domain single-clock strobe.
module bpm_pin_drv
    import bpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pin_n,
    output logic oe
);
    pin_state_e st;
    pin_state_e st_d;

    // Next-state selection
    always_comb begin
        st_d = PIN_IDLE;
        if (fire)                  st_d = PIN_ACTIVE;
        else if (st == PIN_ACTIVE) st_d = PIN_PARK;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PIN_IDLE;
        else        st <= st_d;
    end

    assign pin_n = (st != PIN_ACTIVE);
    assign oe    = (st != PIN_IDLE);
endmodule

// File: rtl/bus_parity_monitor.sv
// Top of the bus parity error reporter. It compares the held expected parity
// with the PAR input, routes a mismatch to the parity-error or the
// system-error pin, and keeps two sticky status flags.
// Assumes PAR for a phase arrives on the clock after that phase.
module bus_parity_monitor
    import bpm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [DATA_W/8-1:0] cbe_n,
    input  logic              par,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              devsel_n,
    input  logic              is_master,
    input  logic              perr_en,
    input  logic              serr_en,
    input  logic [1:0]        flag_clr,
    output logic              perr_n,
    output logic              perr_oe,
    output logic              serr_n,
    output logic              serr_oe,
    output logic              err_seen,
    output logic              serr_sent
);
    localparam int CBE_W    = DATA_W / 8;
    localparam int NUM_PINS = 2;
    localparam int PIN_PERR = 0;
    localparam int PIN_SERR = 1;

    chk_kind_e           kind_q;
    logic                exp_par_q;
    logic                mismatch;
    logic [NUM_PINS-1:0] fire;
    logic [NUM_PINS-1:0] pin_n_v;
    logic [NUM_PINS-1:0] oe_v;

    bpm_phase_track #(
        .DATA_W (DATA_W),
        .CBE_W  (CBE_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ad        (ad),
        .cbe_n     (cbe_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .trdy_n    (trdy_n),
        .devsel_n  (devsel_n),
        .is_master (is_master),
        .kind_q    (kind_q),
        .exp_par_q (exp_par_q)
    );

    // Compare the held parity with PAR and route the result
    always_comb begin
        mismatch       = (kind_q != CHK_NONE) && (par != exp_par_q);
        fire           = '0;
        fire[PIN_PERR] = mismatch && (kind_q == CHK_PDATA) && perr_en;
        fire[PIN_SERR] = mismatch && ((kind_q == CHK_ADDR) || (kind_q == CHK_SDATA)) && serr_en;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        bpm_pin_drv u_drv (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (fire[g]),
            .pin_n (pin_n_v[g]),
            .oe    (oe_v[g])
        );
    end

    assign perr_n  = pin_n_v[PIN_PERR];
    assign perr_oe = oe_v[PIN_PERR];
    assign serr_n  = pin_n_v[PIN_SERR];
    assign serr_oe = oe_v[PIN_SERR];

    // Sticky detected-error flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)          err_seen <= 1'b0;
        else if (mismatch)   err_seen <= 1'b1;
        else if (flag_clr[0]) err_seen <= 1'b0;
    end

    // Sticky system-error-signalled flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)               serr_sent <= 1'b0;
        else if (fire[PIN_SERR])  serr_sent <= 1'b1;
        else if (flag_clr[1])     serr_sent <= 1'b0;
    end
endmodule

// File: rtl/bpm_checker.sv
// Property checker for bus_parity_monitor, bound to every instance.
// Assumes synchronous active-low reset on rst_n.
module bpm_checker (
    input logic clk,
    input logic rst_n,
    input logic irdy_n,
    input logic trdy_n,
    input logic perr_en,
    input logic serr_en,
    input logic perr_n,
    input logic perr_oe,
    input logic serr_n,
    input logic serr_oe,
    input logic err_seen,
    input logic serr_sent
);
    a_r3_perr_two_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(!irdy_n && !trdy_n, 2));

    a_r7_perr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(perr_en));

    a_r7_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(serr_en));

    a_r8_perr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> perr_oe);

    a_r8_serr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> serr_oe);

    a_r8_perr_park: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_n) |-> perr_oe);

    a_r8_serr_park: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serr_n) |-> serr_oe);

    a_r8_perr_release: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe && perr_n) |=> (!perr_oe || !perr_n));

    a_r8_serr_release: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_oe && serr_n) |=> (!serr_oe || !serr_n));

    a_r9_perr_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> err_seen);

    a_r9_serr_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> serr_sent);
endmodule

bind bus_parity_monitor bpm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irdy_n    (irdy_n),
    .trdy_n    (trdy_n),
    .perr_en   (perr_en),
    .serr_en   (serr_en),
    .perr_n    (perr_n),
    .perr_oe   (perr_oe),
    .serr_n    (serr_n),
    .serr_oe   (serr_oe),
    .err_seen  (err_seen),
    .serr_sent (serr_sent)
);

// File: tb/sim_bus_parity_monitor.sv
// Directed bench for bus_parity_monitor: one task per scenario.
module sim_bus_parity_monitor;
    localparam int DW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] ad;
    logic [CW-1:0] cbe_n;
    logic          par, frame_n, irdy_n, trdy_n, devsel_n;
    logic          is_master, perr_en, serr_en;
    logic [1:0]    flag_clr;
    logic          perr_n, perr_oe, serr_n, serr_oe, err_seen, serr_sent;

    always #2 clk = ~clk;

    bus_parity_monitor #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .par(par),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
        .is_master(is_master), .perr_en(perr_en), .serr_en(serr_en),
        .flag_clr(flag_clr), .perr_n(perr_n), .perr_oe(perr_oe),
        .serr_n(serr_n), .serr_oe(serr_oe), .err_seen(err_seen), .serr_sent(serr_sent)
    );

    int   nchk = 0;
    int   nfail = 0;
    int   nstep = 0;
    int   cyc = 0;
    logic ep [8];
    logic es [8];
    logic pend_par = 1'b0;
    logic [1:0] clr_req = 2'b00;
    logic exp_seen = 1'b0;
    logic exp_sent = 1'b0;

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            $display("FAIL watchdog expired act=%0d exp=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%0d exp=%0d (step %0d)", req, what, act, exp, nstep);
        end
    endtask

    // One bus clock: check pins against the expectation, then drive inputs
    task automatic step(input logic fr, input logic ir, input logic tr, input logic dv,
                        input logic [DW-1:0] a, input logic [CW-1:0] c,
                        input bit bad, input bit pe, input bit se);
        int cur;
        int prv;
        @(negedge clk);
        cur = nstep % 8;
        prv = (nstep + 7) % 8;
        chk(perr_n === !ep[cur], "R3", "perr_n", int'(perr_n), int'(!ep[cur]));
        chk(perr_oe === (ep[cur] | ep[prv]), "R8", "perr_oe", int'(perr_oe), int'(ep[cur] | ep[prv]));
        chk(serr_n === !es[cur], "R6", "serr_n", int'(serr_n), int'(!es[cur]));
        chk(serr_oe === (es[cur] | es[prv]), "R8", "serr_oe", int'(serr_oe), int'(es[cur] | es[prv]));
        ep[(nstep + 2) % 8] = pe;
        es[(nstep + 2) % 8] = se;
        frame_n  = fr;
        irdy_n   = ir;
        trdy_n   = tr;
        devsel_n = dv;
        ad       = a;
        cbe_n    = c;
        par      = pend_par;
        pend_par = (^{a, c}) ^ bad;
        flag_clr = clr_req;
        clr_req  = 2'b00;
        nstep++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 1, 1, '0, '1, 0, 0, 0);
    endtask

    task automatic chk_flags(input string req);
        chk(err_seen === exp_seen, req, "err_seen", int'(err_seen), int'(exp_seen));
        chk(serr_sent === exp_sent, req, "serr_sent", int'(serr_sent), int'(exp_sent));
    endtask

    // A full transaction; expectations follow R4, R5, R6, R7
    task automatic xact(input logic [3:0] cmd, input bit dsel, input int nd,
                        input logic [7:0] badm, input bit abad, input logic [7:0] waitm);
        bit special;
        bit se;
        bit own;
        special = (cmd == 4'b0001);
        se = abad && !is_master;
        if (se) exp_seen = 1'b1;
        if (se && serr_en) exp_sent = 1'b1;
        step(0, 1, 1, 1, 32'hC0DE_0000 + DW'(nstep), cmd, abad, 0, se && serr_en);
        for (int i = 0; i < nd; i++) begin
            logic [DW-1:0] d;
            d = 32'h5A3C_96E1 ^ (DW'(i) * 32'h0F1E_2D3B) ^ DW'(nstep);
            if (waitm[i]) step(0, 0, 1, !dsel, ~d, 4'b0000, 1, 0, 0);
            own = is_master ? !cmd[0] : (cmd[0] && dsel);
            if (badm[i] && !special && own) exp_seen = 1'b1;
            if (badm[i] && special && !is_master) begin
                exp_seen = 1'b1;
                if (serr_en) exp_sent = 1'b1;
            end
            step(i == nd - 1, 0, 0, !dsel, d, 4'(i * 5), badm[i],
                 badm[i] && !special && own && perr_en,
                 badm[i] && special && !is_master && serr_en);
        end
        idle(3);
    endtask

    task automatic clear_flags(input logic [1:0] m);
        clr_req = m;
        idle(2);
        if (m[0]) exp_seen = 1'b0;
        if (m[1]) exp_sent = 1'b0;
        chk_flags("R9 clear");
    endtask

    task automatic t_reset;
        rst_n = 0; frame_n = 1; irdy_n = 1; trdy_n = 1; devsel_n = 1;
        ad = '0; cbe_n = '1; par = 0; is_master = 0; perr_en = 1; serr_en = 1; flag_clr = 2'b11;
        for (int i = 0; i < 8; i++) begin ep[i] = 0; es[i] = 0; end
        repeat (3) @(negedge clk);
        chk(perr_n === 1'b1, "R10", "perr_n", int'(perr_n), 1);
        chk(perr_oe === 1'b0, "R10", "perr_oe", int'(perr_oe), 0);
        chk(serr_n === 1'b1, "R10", "serr_n", int'(serr_n), 1);
        chk(serr_oe === 1'b0, "R10", "serr_oe", int'(serr_oe), 0);
        chk_flags("R10");
        flag_clr = 0;
        rst_n = 1;
        idle(2);
    endtask

    // R1 R3 R4: master read, one faulty phase among good ones
    task automatic t_master_read;
        is_master = 1; perr_en = 1; serr_en = 1;
        xact(4'b0110, 0, 4, 8'b0000_0100, 0, 8'h00);
        chk_flags("R1");
        clear_flags(2'b01);
    endtask

    // R2: wait clocks with wrong parity are ignored
    task automatic t_waits;
        is_master = 0;
        xact(4'b0111, 1, 3, 8'h00, 0, 8'b0000_0111);
        chk_flags("R2");
    endtask

    // R3: adjacent faulty phases give one low clock each, continuously
    task automatic t_back_to_back;
        is_master = 0;
        xact(4'b0111, 1, 4, 8'b0000_0110, 0, 8'h00);
        chk_flags("R3");
        clear_flags(2'b01);
    endtask

    // R4: data the agent did not receive, or did not claim, is not reported
    task automatic t_not_receiver;
        is_master = 1;
        xact(4'b0111, 0, 2, 8'b0000_0011, 0, 8'h00);
        is_master = 0;
        xact(4'b0111, 0, 2, 8'b0000_0011, 0, 8'h00);
        xact(4'b0110, 1, 2, 8'b0000_0011, 0, 8'h00);
        chk_flags("R4");
    endtask

    // R5: Special Cycle data error goes to the system error pin
    task automatic t_special;
        is_master = 0;
        xact(4'b0001, 0, 2, 8'b0000_0001, 0, 8'h00);
        chk_flags("R5");
        clear_flags(2'b11);
    endtask

    // R6 R11: address parity, plus a non-idle start that is not an address phase
    task automatic t_addr;
        is_master = 0;
        xact(4'b0110, 1, 1, 8'h00, 1, 8'h00);
        chk_flags("R6");
        clear_flags(2'b11);
        is_master = 1;
        xact(4'b0111, 1, 1, 8'h00, 1, 8'h00);
        chk_flags("R6 master");
        is_master = 0;
        step(0, 1, 1, 1, 32'h1, 4'b0111, 0, 0, 0);
        step(1, 0, 0, 0, 32'h2, 4'b0000, 0, 0, 0);
        step(0, 1, 1, 1, 32'h3, 4'b0110, 1, 0, 0);
        step(1, 1, 1, 1, 32'h0, 4'b1111, 0, 0, 0);
        idle(3);
        chk_flags("R11");
    endtask

    // R7 R9: enables off block pins but not the detection flag
    task automatic t_enables;
        is_master = 0; perr_en = 0; serr_en = 0;
        xact(4'b0111, 1, 2, 8'b0000_0010, 0, 8'h00);
        chk_flags("R7 perr");
        xact(4'b0001, 0, 1, 8'b0000_0001, 1, 8'h00);
        chk_flags("R7 serr");
        perr_en = 1; serr_en = 1;
        clear_flags(2'b11);
    endtask

    // R9: a set in the same clock as a clear wins
    task automatic t_set_wins;
        is_master = 0;
        step(0, 1, 1, 1, 32'hAB00_0001, 4'b0111, 0, 0, 0);
        step(1, 0, 0, 0, 32'h1357_9BDF, 4'b0000, 1, 1, 0);
        clr_req = 2'b01;
        step(1, 1, 1, 1, '0, '1, 0, 0, 0);
        idle(2);
        exp_seen = 1'b1;
        chk_flags("R9 set wins");
        clear_flags(2'b01);
    endtask

    initial begin
        t_reset();
        t_master_read();
        t_waits();
        t_back_to_back();
        t_not_receiver();
        t_special();
        t_addr();
        t_enables();
        t_set_wins();
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule